// File: doc/BRIEF.md
# Priority Task Scheduler with Timeouts

This block keeps the scheduling state of a set of RTOS task contexts in hardware and decides which task should own the CPU. A CPU driver writes one command at a time: an operation code, a task number and a 32-bit argument. Two cycles later the block answers with an error code, the number of the task that should run next, an idle flag, a count value and a flag that says whether the CPU must switch context. The register save and restore is left to the driver.

Each task is dormant, ready, sleeping or waiting for an interrupt event. The running task is the ready task the block last reported. There is no periodic tick. The schedule is re-evaluated only when a command arrives, when an armed timeout expires, or when an interrupt event releases a waiting task. A change that does not come from a command is reported by a one-cycle pulse on a dedicated interrupt line. Timeouts are counted in milliseconds against a free-running timebase, and each task compares its own deadline.

Top module: `task_sched`

## Requirements
- R1: After reset, every task is dormant, `run_valid`, `rsp_valid` and `irq_switch` are 0, and no task runs.
- R2: Opcode 1 (start) moves a dormant task to ready at the priority in `cmd_arg[3:0]`. On a task that is not dormant it returns error 1 (bad state). Every accepted command gets exactly one response, with `rsp_valid` high two cycles after `cmd_valid`.
- R3: The running task is always the ready task with the numerically lowest priority. `rsp_switch` is 1 exactly when the reported next task differs from the task that ran before the command.
- R4: Ready tasks of one priority are served in the order in which they became ready.
- R5: Opcode 7 (rotate) moves the head of the level in `cmd_arg[3:0]` to its tail. On an empty level it has no effect.
- R6: Opcode 2 (sleep) removes the running task from the ready set. A non-zero argument arms a timeout of that many milliseconds. On expiry the task becomes ready again. An argument of 0 sleeps with no timeout.
- R7: Opcode 4 (wakeup) readies a sleeping task. On a ready or waiting task it adds one pending wakeup, and error 3 (overflow) is returned when the count is full. A sleep command with a pending wakeup consumes one wakeup and returns at once with no switch.
- R8: Opcode 5 (cancel wakeup) returns the pending count in `rsp_count` and clears it. On a dormant task it returns error 1.
- R9: Opcode 6 (release) readies a sleeping or waiting task. On any other task it returns error 1.
- R10: Opcode 3 (wait) parks the running task until an event for it arrives on `evt_valid`/`evt_id`. An event for a task that is not waiting has no effect.
- R11: When a timeout or an event changes the selected task outside any command, `irq_switch` pulses for one cycle and `run_id` shows the new task. Tasks whose timeouts expire in the same cycle all become ready together, queued in ascending task number.
- R12: Opcode 0 returns error 4 (bad operation). Sleep or wait with no running task returns error 2 (no task).
- R13: A task preempted by a more urgent one stays at the head of its level and runs again before its peers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle, at most one outstanding |
| cmd_op | input | 3 | Operation code |
| cmd_id | input | ID_W | Target task |
| cmd_arg | input | 32 | Priority, level or timeout in ms |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_id | input | ID_W | Task the event is meant for |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 3 | Error code |
| rsp_switch | output | 1 | Context switch required |
| rsp_idle | output | 1 | No task is ready |
| rsp_next | output | ID_W | Task to run |
| rsp_count | output | WUP_W | Pending wakeups returned by cancel |
| irq_switch | output | 1 | Switch request raised by a timeout or an event |
| run_valid | output | 1 | A task is running |
| run_id | output | ID_W | Running task |

## Verification
The selection is driven with tasks started in rising, falling and equal priority. This separates the choice by priority from the first-come order, and a preemption scenario separates head re-entry from tail entry. Rotation is applied repeatedly and to an empty level, which shows both the queue order and the absence of side effects. Timeouts are tried singly, to bound the expiry window, and then three at once, which shows that simultaneous entrants queue by task number behind a task that was already ready. Events aimed at waiting and at non-waiting tasks tell a real release from one that must be ignored.

// File: rtl/sched_pkg.sv
// Shared encodings for the task scheduler: operation codes, error codes
// and per-task states. Assumes a 3-bit opcode and error field at the ports.
package sched_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_SLEEP   = 3'd2,
        OP_WAIT    = 3'd3,
        OP_WAKE    = 3'd4,
        OP_CANWAKE = 3'd5,
        OP_RELEASE = 3'd6,
        OP_ROTATE  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        E_OK     = 3'd0,
        E_STATE  = 3'd1,
        E_NOTASK = 3'd2,
        E_OVF    = 3'd3,
        E_OP     = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        ST_DORMANT = 2'd0,
        ST_READY   = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_WAIT    = 2'd3
    } tstate_e;

endpackage

// File: rtl/sched_timebase.sv
// Free-running millisecond timebase. A prescaler divides the clock by
// TICK_CYC. Assumes TICK_CYC >= 2. The count wraps at 2^32, and deadlines
// are compared for equality, so the wrap needs no special handling.
module sched_timebase #(
    parameter int TICK_CYC = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] ms_now
);
    localparam int PRE_W = $clog2(TICK_CYC);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_W'(TICK_CYC - 1));

    // Count clock cycles up to one millisecond, then advance the ms count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            ms_now <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            ms_now <= ms_now + 32'd1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    // R6: the timebase moves by exactly one millisecond per prescaler wrap
    p_ms_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ms_now == $past(ms_now) + 32'd1));

endmodule

// File: rtl/sched_pick.sv
// Next-task selection. Each candidate is a ready task at the head of its
// priority level (position 0). A balanced comparison tree keeps the one
// with the lowest priority number. The depth is log2(N), whatever the
// number of ready tasks. Assumes N is a power of two and that at most one
// head exists per level, so ties cannot occur.
module sched_pick #(
    parameter int N      = 16,
    parameter int PRIO_W = 4,
    parameter int POS_W  = 4,
    parameter int ID_W   = 4
) (
    input  logic [N-1:0]      ready,
    input  logic [PRIO_W-1:0] prio [N],
    input  logic [POS_W-1:0]  pos  [N],
    output logic              found,
    output logic [ID_W-1:0]   id
);
    logic              nv [2*N];
    logic [PRIO_W-1:0] np [2*N];
    logic [ID_W-1:0]   ni [2*N];

    // Fill the leaves with the heads, then reduce pairwise up to the root.
    always_comb begin
        nv[0] = 1'b0;
        np[0] = '0;
        ni[0] = '0;
        for (int t = 0; t < N; t++) begin
            nv[N+t] = ready[t] && (pos[t] == '0);
            np[N+t] = prio[t];
            ni[N+t] = ID_W'(t);
        end
        for (int k = N - 1; k >= 1; k--) begin
            if (nv[2*k] && (!nv[2*k+1] || np[2*k] <= np[2*k+1])) begin
                nv[k] = nv[2*k];
                np[k] = np[2*k];
                ni[k] = ni[2*k];
            end else begin
                nv[k] = nv[2*k+1];
                np[k] = np[2*k+1];
                ni[k] = ni[2*k+1];
            end
        end
        found = nv[1];
        id    = ni[1];
    end

endmodule

// File: rtl/task_sched.sv
// Task scheduler top. Holds the state, priority, queue position, deadline
// and pending-wakeup count of every task. Applies one command, any number
// of timeout expiries and one interrupt event in each cycle. The selection
// result is registered one cycle later.
// Assumes: NUM_TASKS is a power of two (>= 2), and the driver keeps at most
// one command outstanding, issuing the next one only after rsp_valid.
module task_sched #(
    parameter int NUM_TASKS = 16,
    parameter int NUM_PRIO  = 16,
    parameter int TICK_CYC  = 100000,
    parameter int WUP_W     = 4,
    localparam int ID_W     = $clog2(NUM_TASKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [ID_W-1:0]  cmd_id,
    input  logic [31:0]      cmd_arg,
    input  logic             evt_valid,
    input  logic [ID_W-1:0]  evt_id,
    output logic             rsp_valid,
    output logic [2:0]       rsp_err,
    output logic             rsp_switch,
    output logic             rsp_idle,
    output logic [ID_W-1:0]  rsp_next,
    output logic [WUP_W-1:0] rsp_count,
    output logic             irq_switch,
    output logic             run_valid,
    output logic [ID_W-1:0]  run_id
);
    import sched_pkg::*;

    localparam int PRIO_W = $clog2(NUM_PRIO);
    localparam int POS_W  = ID_W;
    localparam int CNT_W  = ID_W + 1;
    localparam logic [WUP_W-1:0] WUP_MAX = '1;

    // Per-task registers
    tstate_e           st_q   [NUM_TASKS];
    logic [PRIO_W-1:0] prio_q [NUM_TASKS];
    logic [POS_W-1:0]  pos_q  [NUM_TASKS];
    logic [31:0]       dl_q   [NUM_TASKS];
    logic [WUP_W-1:0]  wup_q  [NUM_TASKS];
    logic [NUM_TASKS-1:0] armed_q;

    // Decode results
    op_e              op;
    err_e             err;
    logic [WUP_W-1:0] cnt_out;
    logic             do_start, do_free, do_leave, do_inc, do_dec, do_clr, do_rot;
    logic [PRIO_W-1:0] rot_lvl;
    logic [CNT_W-1:0]  rot_cnt;

    // Entry bookkeeping
    logic [NUM_TASKS-1:0] ready_v, enter;
    logic [PRIO_W-1:0] eprio [NUM_TASKS];
    logic [POS_W-1:0]  epos  [NUM_TASKS];
    logic [CNT_W-1:0]  ebase [NUM_TASKS];
    logic [CNT_W-1:0]  erank [NUM_TASKS];

    // Response pipeline and timebase
    logic             rsp_pend;
    err_e             err_q;
    logic [WUP_W-1:0] cnt_q;
    logic             pick_found, differ;
    logic [ID_W-1:0]  pick_id;
    logic [31:0]      ms_now;

    sched_timebase #(.TICK_CYC(TICK_CYC)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_now (ms_now)
    );

    sched_pick #(.N(NUM_TASKS), .PRIO_W(PRIO_W), .POS_W(POS_W), .ID_W(ID_W)) u_pick (
        .ready (ready_v),
        .prio  (prio_q),
        .pos   (pos_q),
        .found (pick_found),
        .id    (pick_id)
    );

    // Decode the command against the current state of its target.
    always_comb begin
        op       = op_e'(cmd_op);
        err      = E_OK;
        cnt_out  = '0;
        do_start = 1'b0;
        do_free  = 1'b0;
        do_leave = 1'b0;
        do_inc   = 1'b0;
        do_dec   = 1'b0;
        do_clr   = 1'b0;
        do_rot   = 1'b0;
        rot_lvl  = cmd_arg[PRIO_W-1:0];
        if (cmd_valid) begin
            case (op)
                OP_START: begin
                    if (st_q[cmd_id] == ST_DORMANT) do_start = 1'b1;
                    else err = E_STATE;
                end
                OP_SLEEP, OP_WAIT: begin
                    if (!run_valid || st_q[run_id] != ST_READY) err = E_NOTASK;
                    else if (op == OP_SLEEP && wup_q[run_id] != '0) do_dec = 1'b1;
                    else do_leave = 1'b1;
                end
                OP_WAKE: begin
                    if (st_q[cmd_id] == ST_SLEEP) do_free = 1'b1;
                    else if (st_q[cmd_id] == ST_DORMANT) err = E_STATE;
                    else if (wup_q[cmd_id] == WUP_MAX) err = E_OVF;
                    else do_inc = 1'b1;
                end
                OP_CANWAKE: begin
                    if (st_q[cmd_id] == ST_DORMANT) err = E_STATE;
                    else begin
                        do_clr  = 1'b1;
                        cnt_out = wup_q[cmd_id];
                    end
                end
                OP_RELEASE: begin
                    if (st_q[cmd_id] == ST_SLEEP || st_q[cmd_id] == ST_WAIT) do_free = 1'b1;
                    else err = E_STATE;
                end
                OP_ROTATE: do_rot = 1'b1;
                default:   err = E_OP;
            endcase
        end
    end

    // Find which tasks enter the ready set this cycle, and at what priority.
    always_comb begin
        for (int i = 0; i < NUM_TASKS; i++) begin
            ready_v[i] = (st_q[i] == ST_READY);
            enter[i]   = ((st_q[i] == ST_SLEEP || st_q[i] == ST_WAIT) &&
                          ((armed_q[i] && ms_now == dl_q[i]) ||
                           (evt_valid && evt_id == ID_W'(i) && st_q[i] == ST_WAIT) ||
                           (do_free && cmd_id == ID_W'(i)))) ||
                         (do_start && cmd_id == ID_W'(i));
            eprio[i]   = (do_start && cmd_id == ID_W'(i)) ? cmd_arg[PRIO_W-1:0] : prio_q[i];
        end
    end

    // Tail positions for entrants: the level's remaining size plus the rank by task number.
    always_comb begin
        rot_cnt = '0;
        for (int i = 0; i < NUM_TASKS; i++) begin
            if (ready_v[i] && prio_q[i] == rot_lvl) rot_cnt = rot_cnt + 1'b1;
            ebase[i] = '0;
            erank[i] = '0;
            for (int j = 0; j < NUM_TASKS; j++) begin
                if (ready_v[j] && prio_q[j] == eprio[i]) ebase[i] = ebase[i] + 1'b1;
                if (j < i && enter[j] && eprio[j] == eprio[i]) erank[i] = erank[i] + 1'b1;
            end
            if (do_leave && prio_q[run_id] == eprio[i]) ebase[i] = ebase[i] - 1'b1;
            epos[i] = POS_W'(ebase[i] + erank[i]);
        end
    end

    // Update each task's state, queue position, deadline and wakeup count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= '0;
            for (int i = 0; i < NUM_TASKS; i++) begin
                st_q[i]   <= ST_DORMANT;
                prio_q[i] <= '0;
                pos_q[i]  <= '0;
                dl_q[i]   <= '0;
                wup_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_TASKS; i++) begin
                if (enter[i]) begin
                    st_q[i]    <= ST_READY;
                    prio_q[i]  <= eprio[i];
                    pos_q[i]   <= epos[i];
                    armed_q[i] <= 1'b0;
                end else if (do_leave && run_id == ID_W'(i)) begin
                    st_q[i]    <= (op == OP_SLEEP) ? ST_SLEEP : ST_WAIT;
                    armed_q[i] <= (cmd_arg != '0);
                    dl_q[i]    <= ms_now + cmd_arg;
                end else if (ready_v[i]) begin
                    if (do_leave && prio_q[i] == prio_q[run_id] && pos_q[i] > pos_q[run_id])
                        pos_q[i] <= pos_q[i] - 1'b1;
                    else if (do_rot && prio_q[i] == rot_lvl)
                        pos_q[i] <= (pos_q[i] == '0) ? POS_W'(rot_cnt - 1'b1) : pos_q[i] - 1'b1;
                end
                if (do_start && cmd_id == ID_W'(i))            wup_q[i] <= '0;
                else if (do_inc && cmd_id == ID_W'(i))         wup_q[i] <= wup_q[i] + 1'b1;
                else if (do_dec && run_id == ID_W'(i))         wup_q[i] <= wup_q[i] - 1'b1;
                else if (do_clr && cmd_id == ID_W'(i))         wup_q[i] <= '0;
            end
        end
    end

    assign differ = (pick_found != run_valid) || (pick_found && pick_id != run_id);

    // Register the selection; report it as a response or as a switch interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pend   <= 1'b0;
            err_q      <= E_OK;
            cnt_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= '0;
            rsp_switch <= 1'b0;
            rsp_idle   <= 1'b1;
            rsp_next   <= '0;
            rsp_count  <= '0;
            irq_switch <= 1'b0;
            run_valid  <= 1'b0;
            run_id     <= '0;
        end else begin
            rsp_pend   <= cmd_valid;
            err_q      <= err;
            cnt_q      <= cnt_out;
            rsp_valid  <= rsp_pend;
            rsp_err    <= err_q;
            rsp_count  <= cnt_q;
            rsp_next   <= pick_found ? pick_id : '0;
            rsp_idle   <= !pick_found;
            rsp_switch <= rsp_pend && differ;
            irq_switch <= !rsp_pend && differ;
            run_valid  <= pick_found;
            run_id     <= pick_found ? pick_id : '0;
        end
    end

    // R2: each command is answered exactly two cycles later
    p_rsp_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ##2 rsp_valid);

    // R3: without a switch flag the running task is unchanged
    p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_switch) |-> (run_id == $past(run_id) && run_valid == $past(run_valid)));

    // R6: the task reported with a response is in the ready set
    p_run_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && run_valid) |-> (st_q[run_id] == ST_READY));

    // R11: a switch interrupt names a runnable task and never overlaps a response
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_switch |-> (run_valid && !rsp_valid));

endmodule

// File: tb/task_sched_test.sv
module task_sched_test;
    localparam int TICK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [3:0] cmd_id = '0;
    logic [31:0] cmd_arg = '0;
    logic       evt_valid = 1'b0;
    logic [3:0] evt_id = '0;
    logic       rsp_valid, rsp_switch, rsp_idle, irq_switch, run_valid;
    logic [2:0] rsp_err;
    logic [3:0] rsp_next, run_id;
    logic [1:0] rsp_count;

    typedef struct packed {
        logic [2:0] err;
        logic       sw;
        logic [3:0] nxt;
        logic       idle;
        logic [1:0] cnt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    logic  irq_ok = 1'b0;

    always #5 clk = ~clk;

    task_sched #(.NUM_TASKS(16), .NUM_PRIO(16), .TICK_CYC(TICK), .WUP_W(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_arg(cmd_arg),
        .evt_valid(evt_valid), .evt_id(evt_id),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_switch(rsp_switch),
        .rsp_idle(rsp_idle), .rsp_next(rsp_next), .rsp_count(rsp_count),
        .irq_switch(irq_switch), .run_valid(run_valid), .run_id(run_id)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Monitor: pop the expected response and compare; flag stray interrupts
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t  a;
            a = '{err: rsp_err, sw: rsp_switch, nxt: rsp_next, idle: rsp_idle, cnt: rsp_count};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", $sformatf("unexpected response act=%h exp=none", a));
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a == e, t, $sformatf("act=%h exp=%h", a, e));
            end
        end
        if (rst_n && irq_switch && !irq_ok)
            check(1'b0, "R11", "act irq=1 exp irq=0");
    end

    // Driver: queue the expected response, pulse the command, wait for the answer
    task automatic issue(input logic [2:0] op, input int id, input int arg,
                         input logic [2:0] e, input logic sw, input int nx,
                         input logic idle, input int c, input string tag);
        exp_q.push_back('{err: e, sw: sw, nxt: 4'(nx), idle: idle, cnt: 2'(c)});
        tag_q.push_back(tag);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_id    = 4'(id);
        cmd_arg   = 32'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Wait for a switch interrupt inside a cycle window and check the running task
    task automatic wait_irq(input int minc, input int maxc, input int exp_id, input string tag);
        int  k = 0;
        bit  got = 0;
        irq_ok = 1'b1;
        while (!got && k < maxc) begin
            @(negedge clk);
            k++;
            if (irq_switch) got = 1;
        end
        check(got && k >= minc && run_id == 4'(exp_id), tag,
              $sformatf("act irq=%0d after %0d run=%0d exp irq=1 in [%0d,%0d] run=%0d",
                        got, k, run_id, minc, maxc, exp_id));
        @(posedge clk);
        irq_ok = 1'b0;
    endtask

    task automatic send_evt(input int id);
        evt_valid = 1'b1;
        evt_id    = 4'(id);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!run_valid && !rsp_valid && !irq_switch, "R1",
              $sformatf("act run_valid=%0d rsp_valid=%0d irq=%0d exp 0 0 0", run_valid, rsp_valid, irq_switch));
        // R12: sleep with nothing running
        issue(3'd2, 0, 0, 3'd2, 0, 0, 1, 0, "R12 sleep no task");
        // R2 R3: start tasks in mixed priority order
        issue(3'd1, 3, 5, 3'd0, 1, 3, 0, 0, "R2 start t3");
        issue(3'd1, 3, 5, 3'd1, 0, 3, 0, 0, "R2 start twice");
        issue(3'd1, 1, 7, 3'd0, 0, 3, 0, 0, "R3 less urgent start");
        issue(3'd1, 4, 5, 3'd0, 0, 3, 0, 0, "R4 same level start");
        issue(3'd1, 2, 2, 3'd0, 1, 2, 0, 0, "R3 more urgent preempts");
        // R13: the preempted task resumes ahead of its peer
        issue(3'd2, 0, 0, 3'd0, 1, 3, 0, 0, "R13 preempted resumes at head");
        issue(3'd1, 5, 5, 3'd0, 0, 3, 0, 0, "R4 third at level");
        // R5 R4: rotation walks the arrival order
        issue(3'd7, 0, 5, 3'd0, 1, 4, 0, 0, "R5 rotate to t4");
        issue(3'd7, 0, 5, 3'd0, 1, 5, 0, 0, "R4 rotate to t5");
        issue(3'd7, 0, 5, 3'd0, 1, 3, 0, 0, "R4 rotate back to t3");
        issue(3'd7, 0, 9, 3'd0, 0, 3, 0, 0, "R5 rotate empty level");
        // R7 R8: pending wakeups on a ready task
        issue(3'd4, 1, 0, 3'd0, 0, 3, 0, 0, "R7 wake pend 1");
        issue(3'd4, 1, 0, 3'd0, 0, 3, 0, 0, "R7 wake pend 2");
        issue(3'd4, 1, 0, 3'd0, 0, 3, 0, 0, "R7 wake pend 3");
        issue(3'd4, 1, 0, 3'd3, 0, 3, 0, 0, "R7 wake overflow");
        issue(3'd5, 1, 0, 3'd0, 0, 3, 0, 3, "R8 cancel returns 3");
        issue(3'd5, 1, 0, 3'd0, 0, 3, 0, 0, "R8 cancel returns 0");
        issue(3'd5, 9, 0, 3'd1, 0, 3, 0, 0, "R8 cancel dormant");
        // R7: a pending wakeup makes sleep return at once
        issue(3'd4, 3, 0, 3'd0, 0, 3, 0, 0, "R7 wake running");
        issue(3'd2, 0, 0, 3'd0, 0, 3, 0, 0, "R7 sleep consumes pending");
        issue(3'd4, 2, 0, 3'd0, 1, 2, 0, 0, "R7 wake sleeper");
        // R10: wait and events
        issue(3'd3, 0, 0, 3'd0, 1, 3, 0, 0, "R10 wait");
        send_evt(4);
        repeat (5) @(negedge clk);
        check(run_id == 4'd3 && run_valid, "R10",
              $sformatf("event to ready task act run=%0d exp run=3", run_id));
        irq_ok = 1'b1;
        send_evt(2);
        irq_ok = 1'b0;
        wait_irq(0, 6, 2, "R11 event releases waiter");
        // R9: release
        issue(3'd6, 1, 0, 3'd1, 0, 2, 0, 0, "R9 release ready task");
        issue(3'd2, 0, 0, 3'd0, 1, 3, 0, 0, "R6 sleep forever");
        issue(3'd6, 2, 0, 3'd0, 1, 2, 0, 0, "R9 release sleeper");
        // R12: bad opcode
        issue(3'd0, 0, 0, 3'd4, 0, 2, 0, 0, "R12 bad op");
        // R6 R11: single timeout
        issue(3'd2, 0, 3, 3'd0, 1, 3, 0, 0, "R6 sleep 3 ms");
        wait_irq(2*TICK - 2, 3*TICK + 6, 2, "R6 timeout wakes t2");
        // R11: three timeouts expiring together
        issue(3'd2, 0, 3, 3'd0, 1, 3, 0, 0, "R11 t2 sleeps");
        issue(3'd2, 0, 3, 3'd0, 1, 4, 0, 0, "R11 t3 sleeps");
        issue(3'd2, 0, 3, 3'd0, 1, 5, 0, 0, "R11 t4 sleeps");
        wait_irq(2*TICK - 12, 3*TICK + 6, 2, "R11 joint expiry");
        issue(3'd2, 0, 0, 3'd0, 1, 5, 0, 0, "R11 old head first");
        issue(3'd7, 0, 5, 3'd0, 1, 3, 0, 0, "R11 lower id next");
        issue(3'd7, 0, 5, 3'd0, 1, 4, 0, 0, "R11 higher id last");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule